// File: doc/BRIEF.md
# Burst Store-and-Forward Buffer

This buffer sits between the producer half and the consumer half of a DMA data path. It stores whole bursts. The producer pushes beats with a valid/ready handshake. It marks the beat that closes each burst, and with that closing beat it supplies a flag saying whether the burst also ends the transfer. The consumer sees a burst only after its closing beat has been written. It reads the burst beat by beat. On the final beat of each burst the consumer gets that burst's end-of-transfer flag.

Storage is split into `DEPTH_BURSTS` slots of `BURST_BEATS` beats each. A slot is claimed when a burst starts. It is handed back only when the consumer takes the burst's final beat. The end-of-transfer flags are kept in a separate one-bit memory with one entry per slot. The block reports how many complete bursts it holds. The depth must be a power of two from 2 to 32. Burst length times beat width must not exceed 4096 bytes.

Top module: `burst_sf_buffer`

## Requirements
- R1: After reset `wr_ready` is 1, `rd_valid` is 0 and `bursts_stored` is 0.
- R2: Beats leave on `rd_data` in exactly the order they were accepted on the write side.
- R3: A burst closes on the accepted beat with `wr_last` = 1, or on its `BURST_BEATS`-th accepted beat, whichever comes first. `rd_last` is 1 on exactly that beat when it is read.
- R4: `rd_valid` stays 0 while the only stored data is a burst whose closing beat has not yet been accepted.
- R5: `bursts_stored` counts complete, unreleased bursts. It rises one clock edge after a closing write handshake and changes by at most one per cycle.
- R6: When `bursts_stored` equals `DEPTH_BURSTS`, `wr_ready` is 0 and no write is accepted.
- R7: A slot is freed by the clock edge on which its final beat is read. `bursts_stored` drops by one at that edge and, if the buffer was full, `wr_ready` is 1 afterwards.
- R8: `rd_eot` carries the closing beat's `wr_eot` value on the final beat of the burst and is 0 on every other read beat.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid`, `rd_data` and `rd_last` hold their values.
- R10: `wr_eot` on a beat that does not close a burst has no effect on the flag reported for that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Producer offers a beat |
| wr_ready | output | 1 | Buffer can take a beat |
| wr_data | input | DATA_W | Beat payload |
| wr_last | input | 1 | Beat closes the current burst |
| wr_eot | input | 1 | Burst ends the transfer (sampled on the closing beat) |
| rd_valid | output | 1 | A beat of a complete burst is available |
| rd_ready | input | 1 | Consumer takes the beat |
| rd_data | output | DATA_W | Beat payload |
| rd_last | output | 1 | Final beat of the burst |
| rd_eot | output | 1 | Burst ends the transfer (on the final beat only) |
| bursts_stored | output | $clog2(DEPTH_BURSTS)+1 | Number of complete bursts held |

## Verification
Several properties are checked on every cycle. The occupancy never exceeds the depth and moves by at most one per cycle. A blocked writer never advances the write pointer. A read of a final beat releases exactly one slot. A stalled read output stays frozen. Other behaviour shows only in the bench's scenarios. These are the data ordering, the early and forced closing of bursts, the hiding of a half-written burst, the flag taken from the closing beat alone, and ready returning right after a full buffer drains one burst. The bench checks them against a queue of expected beats.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    // Bursts are capped at 4096 bytes, so a beat index never needs more bits.
    localparam int unsigned SFB_MAX_IDX_W = 12;

    // Bits needed to index n items (at least 1, at most SFB_MAX_IDX_W).
    function automatic int unsigned sfb_bits(input int unsigned n);
        int unsigned w;
        w = 1;
        while (((32'd1 << w) < n) && (w < SFB_MAX_IDX_W)) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/sfb_slot_mem.sv
module sfb_slot_mem #(
    parameter int unsigned WIDTH   = 33,
    parameter int unsigned ENTRIES = 128
) (
    input  logic                       clk,
    input  logic                       we_i,
    input  logic [$clog2(ENTRIES)-1:0] waddr_i,
    input  logic [WIDTH-1:0]           wdata_i,
    input  logic [$clog2(ENTRIES)-1:0] raddr_i,
    output logic [WIDTH-1:0]           rdata_o
);

    // Plain storage array: contents matter only after a write, so no reset.
    logic [WIDTH-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sfb_burst_cursor.sv
module sfb_burst_cursor
    import sfb_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned BEATS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step_i,
    input  logic                          last_i,
    output logic [$clog2(SLOTS):0]        ptr_o,
    output logic [sfb_bits(BEATS)-1:0]    beat_o,
    output logic                          close_o
);

    localparam int unsigned PW = $clog2(SLOTS);
    localparam int unsigned BW = sfb_bits(BEATS);

    typedef struct packed {
        logic [PW:0]   ptr;
        logic [BW-1:0] beat;
    } cursor_t;

    cursor_t state_d, state_q;
    logic    close_d;

    always_comb begin
        state_d = state_q;
        close_d = step_i && (last_i || (state_q.beat == BW'(BEATS - 1)));
        if (step_i) begin
            if (close_d) begin
                state_d.ptr  = state_q.ptr + 1'b1;
                state_d.beat = '0;
            end else begin
                state_d.beat = state_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ptr_o   = state_q.ptr;
    assign beat_o  = state_q.beat;
    assign close_o = close_d;

    AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(state_q.beat) < BEATS); // R3

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q.ptr == $past(state_q.ptr)) ||
                  (state_q.ptr == $past(state_q.ptr) + 1'b1))); // R5

endmodule

// File: rtl/burst_sf_buffer.sv
module burst_sf_buffer
    import sfb_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned BURST_BEATS  = 16,
    parameter int unsigned DEPTH_BURSTS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid,
    output logic                          wr_ready,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          wr_last,
    input  logic                          wr_eot,
    output logic                          rd_valid,
    input  logic                          rd_ready,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          rd_last,
    output logic                          rd_eot,
    output logic [$clog2(DEPTH_BURSTS):0] bursts_stored
);

    localparam int unsigned PW      = $clog2(DEPTH_BURSTS);
    localparam int unsigned BW      = sfb_bits(BURST_BEATS);
    localparam int unsigned ENTRIES = DEPTH_BURSTS * BURST_BEATS;
    localparam int unsigned AW      = $clog2(ENTRIES);
    localparam int unsigned MW      = DATA_W + 1;

    logic [PW:0]   wr_ptr, rd_ptr;
    logic [BW-1:0] wr_beat, rd_beat;
    logic          wr_fire, wr_close, rd_fire, rd_close;
    logic [PW:0]   fill;
    logic [AW-1:0] data_waddr, data_raddr;
    logic [MW-1:0] data_wword, data_rword;
    logic [0:0]    eot_wbit, eot_rbit;

    // Occupancy in complete bursts; the wrap bit separates full from empty.
    assign fill          = wr_ptr - rd_ptr;
    assign bursts_stored = fill;
    assign wr_ready      = !fill[PW];
    assign rd_valid      = (fill != '0);
    assign wr_fire       = wr_valid && wr_ready;
    assign rd_fire       = rd_valid && rd_ready;

    sfb_burst_cursor #(.SLOTS(DEPTH_BURSTS), .BEATS(BURST_BEATS)) u_wr_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (wr_fire),
        .last_i  (wr_last),
        .ptr_o   (wr_ptr),
        .beat_o  (wr_beat),
        .close_o (wr_close)
    );

    sfb_burst_cursor #(.SLOTS(DEPTH_BURSTS), .BEATS(BURST_BEATS)) u_rd_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (rd_fire),
        .last_i  (data_rword[DATA_W]),
        .ptr_o   (rd_ptr),
        .beat_o  (rd_beat),
        .close_o (rd_close)
    );

    assign data_waddr = AW'(wr_ptr[PW-1:0]) * AW'(BURST_BEATS) + AW'(wr_beat);
    assign data_raddr = AW'(rd_ptr[PW-1:0]) * AW'(BURST_BEATS) + AW'(rd_beat);
    assign data_wword = {wr_close, wr_data};

    sfb_slot_mem #(.WIDTH(MW), .ENTRIES(ENTRIES)) u_data_mem (
        .clk     (clk),
        .we_i    (wr_fire),
        .waddr_i (data_waddr),
        .wdata_i (data_wword),
        .raddr_i (data_raddr),
        .rdata_o (data_rword)
    );

    // One bit per slot, written only by the closing beat of a burst.
    assign eot_wbit = wr_eot;

    sfb_slot_mem #(.WIDTH(1), .ENTRIES(DEPTH_BURSTS)) u_eot_mem (
        .clk     (clk),
        .we_i    (wr_close),
        .waddr_i (wr_ptr[PW-1:0]),
        .wdata_i (eot_wbit),
        .raddr_i (rd_ptr[PW-1:0]),
        .rdata_o (eot_rbit)
    );

    assign rd_data = data_rword[DATA_W-1:0];
    assign rd_last = rd_valid && data_rword[DATA_W];
    assign rd_eot  = rd_last && eot_rbit[0];

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fill) <= DEPTH_BURSTS); // R6

    AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> (wr_ptr == $past(wr_ptr))); // R6

    AST_RELEASE_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_close && !wr_close) |=> (fill == $past(fill) - 1'b1)); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last))); // R9

endmodule

// File: tb/tb_burst_sf_buffer.sv
`timescale 1ns/100ps
module tb_burst_sf_buffer;

    localparam int DW = 16;
    localparam int DEPTH = 8;
    localparam int BEATS = 16;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic [DW-1:0] wr_data = '0;
    logic wr_last = 1'b0;
    logic wr_eot = 1'b0;
    logic rd_valid;
    logic rd_ready = 1'b0;
    logic [DW-1:0] rd_data;
    logic rd_last;
    logic rd_eot;
    logic [PW:0] bursts_stored;

    always #2.5 clk = ~clk;

    burst_sf_buffer #(.DATA_W(DW), .BURST_BEATS(BEATS), .DEPTH_BURSTS(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .wr_last(wr_last), .wr_eot(wr_eot),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_last(rd_last), .rd_eot(rd_eot), .bursts_stored(bursts_stored)
    );

    typedef struct {
        logic [DW-1:0] d;
        logic          l;
        logic          e;
    } item_t;

    item_t exp_q[$];
    int total = 0;
    int bad = 0;
    int popped = 0;
    int rd_mode = 0;
    int seq = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: choose rd_ready, then compare each handshaken beat with the queue.
    initial begin
        bit hold_pending;
        logic [DW-1:0] hold_d;
        item_t it;
        hold_pending = 1'b0;
        hold_d = '0;
        forever begin
            @(negedge clk);
            if (hold_pending) begin
                chk(rd_valid && (rd_data == hold_d), "R9", "stalled output held",
                    int'(rd_data), int'(hold_d));
            end
            rd_ready = (rd_mode == 1) ? 1'b1 :
                       (rd_mode == 2) ? (($urandom % 3) != 0) : 1'b0;
            #1;
            hold_pending = rd_valid && !rd_ready;
            hold_d = rd_data;
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "beat with nothing expected", int'(rd_data), -1);
                end else begin
                    it = exp_q.pop_front();
                    chk(rd_data == it.d, "R2", "data order", int'(rd_data), int'(it.d));
                    chk(rd_last == it.l, "R3", "last marker", int'(rd_last), int'(it.l));
                    chk(rd_eot == it.e, "R8 R10", "end-of-transfer flag", int'(rd_eot), int'(it.e));
                    popped++;
                end
            end
        end
    end

    task automatic send_beat(input bit l, input bit e, input bit exp_last);
        item_t it;
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = DW'(seq);
        wr_last  = l;
        wr_eot   = e;
        #1;
        while (!wr_ready) begin
            @(negedge clk);
            #1;
        end
        it.d = DW'(seq);
        it.l = exp_last;
        it.e = exp_last ? e : 1'b0;
        exp_q.push_back(it);
        seq++;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
        wr_eot   = 1'b0;
    endtask

    // Non-closing beats carry a random eot value that must be ignored (R10).
    task automatic send_burst(input int len, input bit mark_last, input bit eot);
        for (int i = 0; i < len; i++) begin
            bit l;
            bit e;
            l = mark_last && (i == len - 1);
            e = (i == len - 1) ? eot : 1'($urandom % 2);
            send_beat(l, e, l || (i == BEATS - 1));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(wr_ready == 1'b1, "R1", "wr_ready after reset", int'(wr_ready), 1);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
        chk(bursts_stored == 0, "R1", "count after reset", int'(bursts_stored), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Half-written burst stays hidden (R4), closes early via wr_last (R3).
        rd_mode = 0;
        send_beat(1'b0, 1'b1, 1'b0);
        send_beat(1'b0, 1'b1, 1'b0);
        send_beat(1'b0, 1'b0, 1'b0);
        idle();
        #1;
        chk(rd_valid == 1'b0, "R4", "partial burst hidden", int'(rd_valid), 0);
        chk(bursts_stored == 0, "R4", "partial burst not counted", int'(bursts_stored), 0);
        send_beat(1'b1, 1'b1, 1'b1);
        idle();
        #1;
        chk(bursts_stored == 1, "R5", "count after close", int'(bursts_stored), 1);
        chk(rd_valid == 1'b1, "R4", "complete burst visible", int'(rd_valid), 1);
        rd_mode = 1;
        wait (popped == 4);
        rd_mode = 0;
        idle();
        #1;
        chk(bursts_stored == 0, "R7", "slot freed after final beat", int'(bursts_stored), 0);

        // Fill every slot with full-length bursts closed by beat count (R3).
        for (int b = 0; b < DEPTH; b++) begin
            send_burst(BEATS, 1'b0, 1'(b % 2));
        end
        idle();
        #1;
        chk(wr_ready == 1'b0, "R6", "wr_ready when full", int'(wr_ready), 0);
        chk(bursts_stored == DEPTH, "R5", "count when full", int'(bursts_stored), DEPTH);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = 16'hdead;
        wr_last  = 1'b1;
        repeat (3) @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
        #1;
        chk(wr_ready == 1'b0, "R6", "still blocked", int'(wr_ready), 0);
        chk(bursts_stored == DEPTH, "R6", "no write accepted when full", int'(bursts_stored), DEPTH);

        rd_mode = 1;
        wait (popped == 4 + BEATS);
        @(negedge clk);
        #1;
        chk(wr_ready == 1'b1, "R7", "ready after one burst drained", int'(wr_ready), 1);
        chk(bursts_stored == DEPTH - 1, "R7", "count after drain", int'(bursts_stored), DEPTH - 1);

        // Mixed traffic with random stalls, lengths and early closes.
        rd_mode = 2;
        for (int n = 0; n < 40; n++) begin
            int len;
            bit ml;
            len = 1 + int'($urandom % BEATS);
            ml = (len < BEATS) ? 1'b1 : 1'($urandom % 2);
            send_burst(len, ml, 1'($urandom % 2));
            repeat ($urandom % 3) idle();
        end
        idle();
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        #1;
        chk(bursts_stored == 0, "R5", "count after full drain", int'(bursts_stored), 0);
        chk(rd_valid == 1'b0, "R4", "nothing visible after drain", int'(rd_valid), 0);
        summary();
    end

endmodule